// File: doc/BRIEF.md
# Eight-Input Sampling Converter Serial Slave

This block models the serial side of an eight-input, 12-bit sampling converter. A controller lowers the select line and sends 16 serial clocks per frame. During each frame the block reads a 3-bit channel number from the data input. In the same frame it shifts out the result for the channel chosen in the frame before. Each input has a parallel sample port that stands in for the analog front end. The block captures the sample of the chosen channel at the start of each frame.

The channel register is reset only at power-up, and it starts at input 0. The first frame after power-up therefore returns input 0, and no dummy frame is needed. The register keeps its value across idle periods of any length. The select line never clears it. A frame that the select line cuts short leaves the register as it was. While the select line stays low, the frames run back to back, and clock 17 opens the next frame.

Top module: `adc_mux_serial`

## Requirements
- R1: A frame is exactly 16 rising `sclk` edges with `cs_n` low. While `cs_n` stays low, rising edge 17 is edge 1 of a new frame, so frames follow each other with no gap.
- R2: The channel number is read from `din` on rising edges 3, 4 and 5 of a frame, MSB first. The value of `din` on every other edge has no effect on which channel is selected.
- R3: The word shifted out during a frame carries the sample of the channel number received in the previous complete frame.
- R4: After `rst_n` is asserted, the selected channel is input 0. The first frame after reset returns input 0 whatever address that frame carries.
- R5: The output word is 16 bits: four zero bits, then the 12-bit sample, MSB first. `dout` changes on falling `sclk` edges. The controller reads word bit 15-(k-1) at rising edge k, so bit 15 is read at edge 1 and bit 0 at edge 16.
- R6: `dout` is 0 while `cs_n` is high.
- R7: The selected channel is held across `cs_n` high periods of any length, including periods in which `sclk` toggles. A falling `cs_n` does not change it.
- R8: If `cs_n` rises before rising edge 16 of a frame, that frame is abandoned. The selected channel keeps the value it had before that frame, and the next frame starts at edge 1.
- R9: The sample is captured at rising edge 1 of a frame. Later changes to `samples` during the same frame do not affect the word being shifted out.
- R10: In a run of back-to-back frames under one `cs_n` low period, every frame returns the channel addressed in the frame just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Frame select, active low |
| din | input | 1 | Serial data in, carrying the channel number |
| samples | input | 96 | Parallel samples; channel i occupies bits [12*i+11:12*i] |
| dout | output | 1 | Serial data out |

## Verification
The hardest case to reach is a frame that is cut short after the channel bits have already been clocked in. The shadow register then holds a new address, but that address must never reach the channel register. The stimulus first completes a frame for a known channel. It then raises `cs_n` right after edge 5 of a frame that carries a different address. A following full frame shows which channel survived. Two further cases are driven: `sclk` toggles while `cs_n` is high, and the samples change in the middle of a frame.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int NCH_DEF   = 8;   // number of inputs
  localparam int RES_DEF   = 12;  // sample width
  localparam int FRAME_DEF = 16;  // clocks per frame
  localparam int ADDR_EDGE = 3;   // first rising edge that carries an address bit
endpackage

// File: rtl/adcs_frame_cnt.sv
module adcs_frame_cnt #(
  parameter int FRAME_LEN = 16,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          sclk,
  input  logic          frm_rst_n,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (cnt == CW'(FRAME_LEN - 1)) cnt_nxt = '0;
    else                           cnt_nxt = cnt + 1'b1;
  end

  // Cleared while the frame select is inactive; counts rising edges otherwise.
  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) cnt <= '0;
    else            cnt <= cnt_nxt;
  end
endmodule

// File: rtl/adcs_addr_reg.sv
module adcs_addr_reg #(
  parameter int FRAME_LEN = 16,
  parameter int NCH       = 8,
  parameter int FIRST     = 3,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(NCH)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [CW-1:0] cnt,
  input  logic          din,
  output logic [AW-1:0] active_ch
);
  localparam int LO = FIRST - 1;
  localparam int HI = FIRST - 2 + AW;

  logic [AW-1:0] shadow, shadow_nxt, active_nxt;
  logic          cap_en, commit_en;

  always_comb begin
    cap_en     = !cs_n && (int'(cnt) >= LO) && (int'(cnt) <= HI);
    commit_en  = !cs_n && (cnt == CW'(FRAME_LEN - 1));
    shadow_nxt = cap_en ? {shadow[AW-2:0], din} : shadow;
    active_nxt = commit_en ? shadow : active_ch;
  end

  // Only power-on reset touches these; the frame select never does.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shadow    <= '0;
      active_ch <= '0;
    end else begin
      shadow    <= shadow_nxt;
      active_ch <= active_nxt;
    end
  end
endmodule

// File: rtl/adcs_shifter.sv
module adcs_shifter #(
  parameter int FRAME_LEN = 16,
  parameter int NCH       = 8,
  parameter int RES       = 12,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(NCH)
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             frm_rst_n,
  input  logic             cs_n,
  input  logic [CW-1:0]    cnt,
  input  logic [AW-1:0]    active_ch,
  input  logic [NCH*RES-1:0] samples,
  output logic             dout_q
);
  logic [FRAME_LEN-1:0] word, word_nxt;
  logic [RES-1:0]       sel;
  logic                 latch_en;
  logic                 dout_nxt;

  always_comb begin
    sel      = samples[int'(active_ch)*RES +: RES];
    latch_en = !cs_n && (cnt == '0);
    word_nxt = latch_en ? {{(FRAME_LEN-RES){1'b0}}, sel} : word;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_nxt;
  end

  // After falling edge k the next bit for rising edge k+1 is presented.
  always_comb begin
    if (cnt == '0) dout_nxt = 1'b0;
    else           dout_nxt = word[CW'(FRAME_LEN - 1) - cnt];
  end

  always_ff @(negedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) dout_q <= 1'b0;
    else            dout_q <= dout_nxt;
  end
endmodule

// File: rtl/adc_mux_serial.sv
module adc_mux_serial
  import adcs_pkg::*;
#(
  parameter int NCH       = NCH_DEF,
  parameter int RES       = RES_DEF,
  parameter int FRAME_LEN = FRAME_DEF,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(NCH)
) (
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               din,
  input  logic [NCH*RES-1:0] samples,
  output logic               dout
);
  logic          frm_rst_n;
  logic [CW-1:0] frame_cnt;
  logic [AW-1:0] active_ch;
  logic          dout_q;

  assign frm_rst_n = rst_n & ~cs_n;

  adcs_frame_cnt #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .sclk(sclk), .frm_rst_n(frm_rst_n), .cnt(frame_cnt)
  );

  adcs_addr_reg #(.FRAME_LEN(FRAME_LEN), .NCH(NCH), .FIRST(ADDR_EDGE)) u_addr (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cnt(frame_cnt),
    .din(din), .active_ch(active_ch)
  );

  adcs_shifter #(.FRAME_LEN(FRAME_LEN), .NCH(NCH), .RES(RES)) u_shift (
    .sclk(sclk), .rst_n(rst_n), .frm_rst_n(frm_rst_n), .cs_n(cs_n),
    .cnt(frame_cnt), .active_ch(active_ch), .samples(samples), .dout_q(dout_q)
  );

  assign dout = dout_q & ~cs_n;
endmodule

// File: rtl/adcs_chk.sv
module adcs_chk
  import adcs_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_DEF,
  parameter int NCH       = NCH_DEF,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(NCH)
) (
  input logic          rst_n,
  input logic          sclk,
  input logic          cs_n,
  input logic          dout,
  input logic [CW-1:0] frame_cnt,
  input logic [AW-1:0] active_ch
);
  // R1
  frame_wrap_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (frame_cnt == CW'(FRAME_LEN - 1)) |=> (frame_cnt == '0));

  // R5
  lead_zero_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (frame_cnt >= CW'(1) && frame_cnt <= CW'(4)) |-> !dout);

  // R7
  idle_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> $stable(active_ch));

  // R8
  commit_only_at_end_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(active_ch) |-> (frame_cnt == '0));
endmodule

bind adc_mux_serial adcs_chk #(.FRAME_LEN(FRAME_LEN), .NCH(NCH)) u_chk (
  .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dout(dout),
  .frame_cnt(frame_cnt), .active_ch(active_ch)
);

// File: tb/sim_adc_mux_serial.sv
module sim_adc_mux_serial;
  localparam int CLK_PERIOD = 40;
  localparam int NCH = 8;
  localparam int RES = 12;

  logic rst_n, sclk, cs_n, din, dout;
  logic [NCH*RES-1:0] samples;
  int total, bad, seed, chg_at;

  adc_mux_serial u0 (.rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
                     .samples(samples), .dout(dout));

  function automatic logic [11:0] sval(int ch, int s);
    return 12'((ch * 419 + s * 53 + 5) & 12'hFFF);
  endfunction

  task automatic load_samples();
    for (int c = 0; c < NCH; c++) samples[c*RES +: RES] = sval(c, seed);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive nbits clocks of a frame; rx[16-k] holds dout read before rising edge k.
  task automatic clock_bits(int nbits, logic [2:0] addr, logic junk, output logic [15:0] rx);
    rx = '0;
    for (int k = 1; k <= nbits; k++) begin
      din = (k >= 3 && k <= 5) ? addr[5-k] : junk;
      #(CLK_PERIOD/4);
      rx[16-k] = dout;
      #(CLK_PERIOD/4);
      sclk = 1'b1;
      if (k == chg_at) begin seed++; load_samples(); end
      #(CLK_PERIOD/2);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();  #(CLK_PERIOD/4); cs_n = 1'b0; #(CLK_PERIOD/4); endtask
  task automatic cs_high(); #(CLK_PERIOD/4); cs_n = 1'b1; #(CLK_PERIOD/2); endtask

  task automatic one_frame(logic [2:0] addr, logic junk, output logic [15:0] rx);
    cs_low();
    clock_bits(16, addr, junk, rx);
    cs_high();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    logic [2:0] prev;
    int exp_seed;
    total = 0; bad = 0; seed = 1; chg_at = -1;
    sclk = 0; cs_n = 1; din = 0; rst_n = 0;
    load_samples();
    #(CLK_PERIOD*2);
    rst_n = 1;
    #(CLK_PERIOD);
    chk("R6 dout idle after reset", 32'(dout), 0);

    // R4: first frame after reset returns input 0
    one_frame(3'd3, 1'b1, rx);
    chk("R4 first frame input0", 32'(rx), 32'({4'b0, sval(0, seed)}));
    chk("R5 leading zeros", 32'(rx[15:12]), 0);
    chk("R6 dout low after frame", 32'(dout), 0);
    prev = 3'd3;

    // R2 R3: sweep every channel with both junk levels
    for (int j = 0; j < 2; j++)
      for (int a = 0; a < NCH; a++) begin
        logic [2:0] na;
        na = 3'((a * 5 + j) % NCH);
        one_frame(na, 1'(j), rx);
        chk("R3 R2 previous-frame channel", 32'(rx), 32'({4'b0, sval(int'(prev), seed)}));
        prev = na;
      end

    // R10 R1: back-to-back frames under one select low period
    cs_low();
    for (int f = 0; f < 9; f++) begin
      logic [2:0] na;
      na = 3'(7 - (f % 8));
      clock_bits(16, na, 1'(f), rx);
      chk("R10 R1 continuous frame", 32'(rx), 32'({4'b0, sval(int'(prev), seed)}));
      prev = na;
    end
    cs_high();

    // R8: abandoned frame after address bits
    one_frame(3'd2, 1'b0, rx);
    prev = 3'd2;
    cs_low();
    clock_bits(5, 3'd6, 1'b1, rx);
    cs_high();
    chk("R6 dout low after abort", 32'(dout), 0);
    one_frame(3'd4, 1'b0, rx);
    chk("R8 abort keeps channel", 32'(rx), 32'({4'b0, sval(2, seed)}));
    prev = 3'd4;

    // R7: clocks toggling with select high, long idle
    for (int i = 0; i < 60; i++) begin
      din = 1'(i);
      #(CLK_PERIOD/2); sclk = 1; #(CLK_PERIOD/2); sclk = 0;
    end
    #(CLK_PERIOD*50);
    one_frame(3'd1, 1'b1, rx);
    chk("R7 hold across idle", 32'(rx), 32'({4'b0, sval(4, seed)}));
    prev = 3'd1;

    // R9: samples change inside a frame
    exp_seed = seed;
    chg_at = 2;
    one_frame(3'd5, 1'b0, rx);
    chg_at = -1;
    chk("R9 sample captured at edge1", 32'(rx), 32'({4'b0, sval(1, exp_seed)}));
    one_frame(3'd0, 1'b0, rx);
    chk("R9 R3 new samples next frame", 32'(rx), 32'({4'b0, sval(5, seed)}));

    // R4: reset mid-run
    one_frame(3'd6, 1'b1, rx);
    rst_n = 0; #(CLK_PERIOD); rst_n = 1; #(CLK_PERIOD);
    one_frame(3'd2, 1'b1, rx);
    chk("R4 reset restores input0", 32'(rx), 32'({4'b0, sval(0, seed)}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule